// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a down-counting watchdog that software must service at regular intervals. A register port gives access to the control bits, the reload (timeout) value, a service register, a count readback register and a stored service key. The counter starts running as soon as reset is released. Each correct service reloads it from the timeout value. If the counter runs out first, the block raises a one-cycle expiry pulse, which the system uses as a reset request, and the counter starts a new period.

There are two service styles.
- **Fixed pair:** two back-to-back bus writes of fixed constants to the service register.
- **Rolling key:** every service value must equal a key derived from the previously accepted key. Each accepted value then becomes the seed for the next key.

Two lock bits freeze the configuration and the stored key. The soft lock can be lifted by software. The hard lock stays set until reset.

Register map (word index on `reg_addr`): 0 control, 1 timeout, 2 service, 3 count readback, 4 service key. Control bits: bit 0 run, bit 1 keyed mode, bit 2 soft lock, bit 3 hard lock.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the control register reads 0x1 (run set; keyed mode, soft lock and hard lock clear). The timeout reads its reset parameter. The key register reads 0. `expire_o` is low.
- R2: While run is set the counter drops by one each cycle. While run is clear it holds its value.
- R3: Register 3 reads the counter value while run is clear, and reads 0 while run is set.
- R4: Once the counter has been loaded with timeout value T and run is set, with no service after that, `expire_o` is high for exactly the one cycle that starts T+1 clock edges after the loading edge. On that same edge the counter reloads to T.
- R5: With keyed mode clear, a write of 0xA602 to register 2 that is directly followed by a write of 0xB480 to register 2 reloads the counter from the timeout value. If any other write comes between the two, there is no reload.
- R6: With keyed mode set, the only service write accepted is the value (17*K+3) mod 65536, where K is the stored key. That write reloads the counter and stores the written value as the new K. Any other service write, including the fixed pair, has no effect.
- R7: The key register (bits 15:0) takes bus writes while both lock bits are clear. It is read-only while either lock bit is set.
- R8: While either lock bit is set, writes to the timeout register are ignored. Writes to the control register are also ignored, apart from the unlock write in R9.
- R9: While only the soft lock is set, a control write with bit 2 clear clears the soft lock and leaves the other control bits unchanged. The hard lock cannot be cleared by any write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from `reg_addr` |
| expire_o | output | 1 | One-cycle expiry pulse (reset request) |

## Verification
A write is taken at the clock edge on which `reg_we` is sampled high, and its effect can be read back from the next cycle on. The bench therefore drives at falling edges and reads one time unit after a falling edge.

After a reload edge L with timeout T, expiry is due on edge L+T+1. The bench records the edge number of every accepted write and pushes L+T+1 into a queue. A monitor pops that entry when `expire_o` is seen, and flags any pulse on a different edge or with no entry queued.

Stopping the counter one edge after an expiry must leave T-1 in the readback register. This checks the per-cycle decrement without looking inside the design.

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int DATA_W = 32,
  parameter int KEY_W = 16,
  parameter int ADDR_W = 3,
  parameter logic [DATA_W-1:0] TIMEOUT_RST = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              expire_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TMO  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SVC  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(4);
  localparam logic [DATA_W-1:0] PAIR_A = DATA_W'(16'hA602);
  localparam logic [DATA_W-1:0] PAIR_B = DATA_W'(16'hB480);
  localparam logic [KEY_W-1:0]  K_MUL  = KEY_W'(17);
  localparam logic [KEY_W-1:0]  K_ADD  = KEY_W'(3);

  logic              run, keyed, soft_lk, hard_lk, armed;
  logic [DATA_W-1:0] tmo, cnt;
  logic [KEY_W-1:0]  key, key_next;

  wire locked = soft_lk | hard_lk;
  wire wr_ctrl = reg_we && reg_addr == A_CTRL;
  wire wr_tmo  = reg_we && reg_addr == A_TMO;
  wire wr_svc  = reg_we && reg_addr == A_SVC;
  wire wr_key  = reg_we && reg_addr == A_KEY;

  assign key_next = key * K_MUL + K_ADD;

  wire svc_key_ok  = wr_svc && keyed &&
                     reg_wdata == {{(DATA_W-KEY_W){1'b0}}, key_next};
  wire svc_pair_ok = wr_svc && !keyed && armed && reg_wdata == PAIR_B;
  wire reload      = svc_key_ok | svc_pair_ok;
  wire hit_zero    = run && cnt == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b1;
      keyed    <= 1'b0;
      soft_lk  <= 1'b0;
      hard_lk  <= 1'b0;
      armed    <= 1'b0;
      tmo      <= TIMEOUT_RST;
      cnt      <= TIMEOUT_RST;
      key      <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= hit_zero && !reload;

      if (reload || hit_zero) cnt <= tmo;
      else if (run)           cnt <= cnt - 1'b1;

      if (reg_we) armed <= wr_svc && !keyed && reg_wdata == PAIR_A;

      if (wr_ctrl) begin
        if (!locked) begin
          run     <= reg_wdata[0];
          keyed   <= reg_wdata[1];
          soft_lk <= reg_wdata[2];
          hard_lk <= reg_wdata[3];
        end else if (!hard_lk && !reg_wdata[2]) begin
          soft_lk <= 1'b0;
        end
      end

      if (wr_tmo && !locked) tmo <= reg_wdata;

      if (svc_key_ok)                key <= reg_wdata[KEY_W-1:0];
      else if (wr_key && !locked)    key <= reg_wdata[KEY_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = DATA_W'({hard_lk, soft_lk, keyed, run});
      A_TMO:   reg_rdata = tmo;
      A_CNT:   reg_rdata = run ? '0 : cnt;
      A_KEY:   reg_rdata = DATA_W'(key);
      default: reg_rdata = '0;
    endcase
  end
endmodule

module keyed_wdog_chk #(
  parameter int DATA_W = 32,
  parameter int KEY_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              expire_o,
  input logic              run,
  input logic              soft_lk,
  input logic              hard_lk,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] tmo,
  input logic [KEY_W-1:0]  key,
  input logic              reload
);
  // R9
  hard_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_lk |=> hard_lk);
  // R3
  hidden_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && reg_addr == ADDR_W'(3)) |-> reg_rdata == '0);
  // R8
  locked_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(1) && (soft_lk || hard_lk)) |=> $stable(tmo));
  // R7
  locked_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(4) && (soft_lk || hard_lk) && !reload) |=> $stable(key));
  // R4
  expire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expire_o) |-> $past(run && cnt == '0));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0 && !reload) |=> cnt == $past(cnt) - 1'b1);
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reload) |=> $stable(cnt));
endmodule

bind keyed_wdog keyed_wdog_chk #(.DATA_W(DATA_W), .KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .expire_o(expire_o), .run(run), .soft_lk(soft_lk),
  .hard_lk(hard_lk), .cnt(cnt), .tmo(tmo), .key(key), .reload(reload)
);

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TRST = 32'h0000_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        expire_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int exp_q[$];
  int e, s;
  logic [31:0] v;
  logic [15:0] k;

  keyed_wdog #(.TIMEOUT_RST(TRST)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .expire_o(expire_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output int edge_no);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    edge_no = cyc + 1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_edge(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  function automatic logic [15:0] nk(input logic [15:0] kk);
    return 16'((32'(kk) * 17 + 3) & 32'hFFFF);
  endfunction

  // scoreboard monitor: each expiry pulse must match the queued edge number
  always @(negedge clk) begin
    if (rst_n && expire_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4 unexpected expiry actual=%0d expected=none", cyc);
      end else begin
        int want;
        want = exp_q.pop_front();
        if (want != cyc) begin
          fails++;
          $display("FAIL R4 expiry edge actual=%0d expected=%0d", cyc, want);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 32'h1);
    rd(3'd1, v); chk("R1 timeout", v, TRST);
    rd(3'd4, v); chk("R1 key", v, 32'h0);
    chk("R1 expire", 32'(expire_o), 32'h0);
    rd(3'd3, v); chk("R3 hidden while running", v, 32'h0);

    // stop, check hold
    wr(3'd0, 32'h0, e);
    rd(3'd3, v);
    repeat (5) @(negedge clk);
    begin logic [31:0] v2; rd(3'd3, v2); chk("R2 hold while stopped", v2, v); end

    // fixed-pair service while stopped
    wr(3'd1, 32'd30, e);
    rd(3'd1, v); chk("R8 timeout write unlocked", v, 32'd30);
    wr(3'd2, 32'hA602, e); wr(3'd2, 32'hB480, e);
    rd(3'd3, v); chk("R5 pair reload", v, 32'd30);

    // free-running expiry
    wr(3'd0, 32'h1, e);
    exp_q.push_back(e + 31);
    wait_edge(e + 31);
    rd(3'd3, v); chk("R3 hidden after expiry", v, 32'h0);
    wr(3'd0, 32'h0, s);
    rd(3'd3, v); chk("R2 R4 reload then decrement", v, 32'd29);

    // service while running postpones expiry
    wr(3'd0, 32'h1, e);
    repeat (3) @(negedge clk);
    wr(3'd2, 32'hA602, s); wr(3'd2, 32'hB480, s);
    exp_q.push_back(s + 31);
    wait_edge(s + 31);
    wr(3'd0, 32'h0, s);
    rd(3'd3, v); chk("R5 running service", v, 32'd29);

    // broken pair does not reload
    wr(3'd2, 32'hA602, s); wr(3'd2, 32'hB480, s);
    wr(3'd0, 32'h1, e);
    exp_q.push_back(e + 31);
    wr(3'd2, 32'hA602, s); wr(3'd4, 32'd7, s); wr(3'd2, 32'hB480, s);
    wr(3'd2, 32'hA602, s); wr(3'd2, 32'h1234, s); wr(3'd2, 32'hB480, s);
    wait_edge(e + 31);
    wr(3'd0, 32'h0, s);
    rd(3'd3, v); chk("R5 interrupted pair ignored", v, 32'd29);
    rd(3'd4, v); chk("R7 key write unlocked", v, 32'd7);

    // keyed mode
    wr(3'd0, 32'h2, s);
    wr(3'd1, 32'd40, s);
    wr(3'd4, 32'd5, s);
    wr(3'd2, 32'd87, s);
    rd(3'd3, v); chk("R6 wrong key no reload", v, 32'd29);
    rd(3'd4, v); chk("R6 wrong key kept", v, 32'd5);
    wr(3'd2, 32'd88, s);
    rd(3'd3, v); chk("R6 right key reload", v, 32'd40);
    rd(3'd4, v); chk("R6 key stored", v, 32'd88);
    wr(3'd4, 32'hFFFF, s);
    wr(3'd2, 32'hFFF2, s);
    rd(3'd4, v); chk("R6 key wrap", v, 32'hFFF2);
    wr(3'd1, 32'd50, s);
    wr(3'd2, 32'hA602, s); wr(3'd2, 32'hB480, s);
    rd(3'd3, v); chk("R6 pair ignored in keyed", v, 32'd40);
    wr(3'd0, 32'h3, e);
    k = nk(16'hFFF2);
    wr(3'd2, 32'(k), s);
    exp_q.push_back(s + 51);
    wait_edge(s + 51);
    wr(3'd0, 32'h2, s);
    rd(3'd3, v); chk("R6 keyed running reload", v, 32'd49);

    // soft lock
    wr(3'd0, 32'h6, s);
    rd(3'd0, v); chk("R8 ctrl set lock", v, 32'h6);
    wr(3'd1, 32'd99, s);
    rd(3'd1, v); chk("R8 timeout locked", v, 32'd50);
    wr(3'd4, 32'd1, s);
    rd(3'd4, v); chk("R7 key locked", v, 32'(k));
    wr(3'd0, 32'h1, s);
    rd(3'd0, v); chk("R9 soft unlock", v, 32'h2);

    // hard lock
    wr(3'd0, 32'hA, s);
    wr(3'd0, 32'h0, s);
    rd(3'd0, v); chk("R9 hard lock sticky", v, 32'hA);
    wr(3'd1, 32'd77, s);
    rd(3'd1, v); chk("R8 timeout hard locked", v, 32'd50);
    wr(3'd2, 32'(nk(k)), s);
    rd(3'd4, v); chk("R6 keyed service under lock", v, 32'(nk(k)));

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R4 missing expiry actual=%0d expected=0", exp_q.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule